// File: doc/BRIEF.md
# ADC Calibration Source Sequencer

This block walks a sigma-delta ADC front end through the measurements needed for per-channel offset and gain correction. After a start command it visits each channel in turn, from channel 0 upwards. On every channel it selects four input sources, one after another. For each source it waits a fixed settling time with the converter running. It then discards the first few filtered samples, which only load the differencing stages of the decimation filter, and averages a power-of-two number of the samples that follow.

The block receives filtered samples as a data word with a valid strobe. It drives a source-select code and a channel index to the analog mux. It returns one averaged result per source as a single-cycle strobe. Each result carries the channel and the source it belongs to. The modulator and the filter sit outside this block. The settling length, the number of discarded samples, the averaging depth, the data width and the largest channel count are all parameters.

Top module: `adcal_sequencer`

## Requirements
- R1: While reset is held and after it is released, `busy` and `res_valid` are 0 and `src_sel` and `chan_sel` are 0.
- R2: When `start` is high, `busy` is 0 and `num_ch` is non-zero, the count is latched and `busy` rises on the next cycle. A `start` while `busy` is 1 is ignored, and so is any change of `num_ch` while `busy` is 1. A `start` with `num_ch` equal to 0 leaves `busy` at 0.
- R3: The four sources are visited in a fixed order for each channel: code 0 ground reference, code 1 supply reference, code 2 pin driven low, code 3 pin driven high. Channels run from 0 up to the latched count minus 1. The first source after start is code 0 on channel 0.
- R4: A valid sample that arrives in any of the first WARM_CYCLES clock cycles in which a new source or channel is presented is ignored.
- R5: After the settling time, the next PRIME_CNT valid samples (default 4) are discarded.
- R6: The next 2^AVG_LOG2 valid samples (default 16) are summed in an accumulator that cannot overflow. The result is the sum shifted right by AVG_LOG2 (truncating in the default mode), so a full-scale input yields a full-scale result.
- R7: `res_valid` is a one-cycle pulse in the cycle after the last averaged sample is taken. `res_chan` and `res_src` in that cycle equal the channel and source that were measured.
- R8: `src_sel` and `chan_sel` change only in the cycle after a `res_valid` pulse. After the result for code 3 on the last channel, `busy` falls and both selects return to 0 on the next cycle.
- R9: Cycles with `smp_valid` low have no effect, whatever value `smp_data` has.
- R10: A `num_ch` value above NUM_CH_MAX (default 64) is treated as NUM_CH_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a calibration run when idle |
| num_ch | input | $clog2(NUM_CH_MAX+1) | Number of channels to calibrate |
| smp_valid | input | 1 | Filtered sample strobe |
| smp_data | input | DATA_W | Filtered sample value, unsigned |
| src_sel | output | 2 | Source code driven to the input mux |
| chan_sel | output | $clog2(NUM_CH_MAX) | Channel under measurement |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Averaged reading |
| res_chan | output | $clog2(NUM_CH_MAX) | Channel of the result |
| res_src | output | 2 | Source code of the result |

## Verification
The checker assumes that at most one sample arrives per clock and that the samples come from a filter that keeps running, so the settling window ends without any help from the sample stream. It also assumes that `start` is a level that is only acted on when the block is idle. The stimulus keeps to this. It drives a valid sample in the last settling cycle and places random data with the strobe low in the gaps. It pulses `start` and changes `num_ch` in the middle of a run, and it keeps the strobe low while a result is being reported.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [1:0] {
      SRC_GND_REF = 2'd0,
      SRC_SUP_REF = 2'd1,
      SRC_PIN_LO  = 2'd2,
      SRC_PIN_HI  = 2'd3
   } cal_src_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_PRIME,
      ST_ACCUM,
      ST_REPORT
   } cal_state_e;

   localparam int SRC_W = 2;

endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
   parameter int SETTLE_CYCLES = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int TW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;
   localparam logic [TW-1:0] LOAD_VAL = TW'(SETTLE_CYCLES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= LOAD_VAL;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/cal_smp_counter.sv
module cal_smp_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/cal_avg_accum.sv
module cal_avg_accum #(
   parameter int DATA_W     = 27,
   parameter int AVG_LOG2   = 4,
   parameter int TAG_W      = 8,
   parameter int ROUND_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic              last,
   input  logic [DATA_W-1:0] din,
   input  logic [TAG_W-1:0]  tag_in,
   output logic [DATA_W-1:0] avg_out,
   output logic [TAG_W-1:0]  tag_out
);
   localparam int SUM_W = DATA_W + AVG_LOG2;
   localparam int SW1   = SUM_W + 1;
   localparam logic [SW1-1:0] FULL = SW1'({DATA_W{1'b1}});

   logic [SUM_W-1:0]  sum_q;
   logic [SUM_W-1:0]  sum_n;
   logic [SW1-1:0]    biased;
   logic [SW1-1:0]    avg_wide;
   logic [DATA_W-1:0] avg_n;
   logic [DATA_W-1:0] avg_q;
   logic [TAG_W-1:0]  tag_q;

   assign sum_n = sum_q + SUM_W'(din);

   generate
      if (ROUND_MODE == 0) begin : g_trunc
         assign biased = {1'b0, sum_n};
      end else begin : g_round
         localparam logic [SW1-1:0] HALF = SW1'(1) << (AVG_LOG2 - 1);
         assign biased = {1'b0, sum_n} + HALF;
      end
   endgenerate

   assign avg_wide = biased >> AVG_LOG2;
   assign avg_n    = (avg_wide > FULL) ? {DATA_W{1'b1}} : avg_wide[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sum_q <= '0;
      else if (clr)
         sum_q <= '0;
      else if (add)
         sum_q <= sum_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avg_q <= '0;
         tag_q <= '0;
      end else if (add && last) begin
         avg_q <= avg_n;
         tag_q <= tag_in;
      end
   end

   assign avg_out = avg_q;
   assign tag_out = tag_q;

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
   import cal_seq_pkg::*;
#(
   parameter int NUM_CH_MAX = 64,
   parameter int PRIME_CNT  = 4,
   parameter int AVG_LOG2   = 4,
   parameter int CNT_W      = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [$clog2(NUM_CH_MAX+1)-1:0] num_ch,
   input  logic                          smp_valid,
   input  logic                          settle_done,
   input  logic [CNT_W-1:0]              smp_cnt,
   output logic                          settle_load,
   output logic                          settle_run,
   output logic                          cnt_clr,
   output logic                          cnt_inc,
   output logic                          acc_clr,
   output logic                          acc_add,
   output logic                          acc_last,
   output logic [SRC_W-1:0]              src_sel,
   output logic [$clog2(NUM_CH_MAX)-1:0] chan_sel,
   output logic                          busy,
   output logic                          res_valid
);
   localparam int NC_W  = $clog2(NUM_CH_MAX + 1);
   localparam int CH_W  = $clog2(NUM_CH_MAX);
   localparam int N_AVG = 1 << AVG_LOG2;
   localparam logic [CNT_W-1:0] PRIME_LAST = CNT_W'((PRIME_CNT > 0) ? PRIME_CNT - 1 : 0);
   localparam logic [CNT_W-1:0] AVG_LAST   = CNT_W'(N_AVG - 1);
   localparam logic [NC_W-1:0]  NC_CAP     = NC_W'(NUM_CH_MAX);
   localparam cal_state_e AFTER_SETTLE     = (PRIME_CNT > 0) ? ST_PRIME : ST_ACCUM;

   cal_state_e       state_q, state_n;
   cal_src_e         src_q, src_n;
   logic [CH_W-1:0]  chan_q, chan_n;
   logic [CH_W-1:0]  last_ch_q, last_ch_n;
   logic [NC_W-1:0]  eff_count;
   logic             seq_end;

   assign eff_count = (num_ch > NC_CAP) ? NC_CAP : num_ch;
   assign seq_end   = (src_q == SRC_PIN_HI) && (chan_q == last_ch_q);

   always_comb begin
      state_n     = state_q;
      src_n       = src_q;
      chan_n      = chan_q;
      last_ch_n   = last_ch_q;
      settle_load = 1'b0;
      cnt_clr     = 1'b0;
      cnt_inc     = 1'b0;
      acc_add     = 1'b0;
      acc_last    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start && (num_ch != '0)) begin
               state_n     = ST_SETTLE;
               src_n       = SRC_GND_REF;
               chan_n      = '0;
               last_ch_n   = CH_W'(eff_count - 1'b1);
               settle_load = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (settle_done) begin
               state_n = AFTER_SETTLE;
               cnt_clr = 1'b1;
            end
         end
         ST_PRIME: begin
            if (smp_valid) begin
               if (smp_cnt == PRIME_LAST) begin
                  state_n = ST_ACCUM;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
         end
         ST_ACCUM: begin
            if (smp_valid) begin
               acc_add = 1'b1;
               cnt_inc = 1'b1;
               if (smp_cnt == AVG_LAST) begin
                  acc_last = 1'b1;
                  state_n  = ST_REPORT;
               end
            end
         end
         ST_REPORT: begin
            if (seq_end) begin
               state_n = ST_IDLE;
               src_n   = SRC_GND_REF;
               chan_n  = '0;
            end else begin
               state_n     = ST_SETTLE;
               settle_load = 1'b1;
               src_n       = cal_src_e'(src_q + 2'd1);
               if (src_q == SRC_PIN_HI)
                  chan_n = chan_q + 1'b1;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         src_q     <= SRC_GND_REF;
         chan_q    <= '0;
         last_ch_q <= '0;
      end else begin
         state_q   <= state_n;
         src_q     <= src_n;
         chan_q    <= chan_n;
         last_ch_q <= last_ch_n;
      end
   end

   assign settle_run = (state_q == ST_SETTLE);
   assign acc_clr    = (state_q != ST_ACCUM);
   assign src_sel    = src_q;
   assign chan_sel   = chan_q;
   assign busy       = (state_q != ST_IDLE);
   assign res_valid  = (state_q == ST_REPORT);

endmodule

// File: rtl/adcal_sequencer.sv
module adcal_sequencer
   import cal_seq_pkg::*;
#(
   parameter int DATA_W        = 27,
   parameter int NUM_CH_MAX    = 64,
   parameter int SETTLE_CYCLES = 2500,
   parameter int PRIME_CNT     = 4,
   parameter int AVG_LOG2      = 4,
   parameter int ROUND_MODE    = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [$clog2(NUM_CH_MAX+1)-1:0] num_ch,
   input  logic                            smp_valid,
   input  logic [DATA_W-1:0]               smp_data,
   output logic [1:0]                      src_sel,
   output logic [$clog2(NUM_CH_MAX)-1:0]   chan_sel,
   output logic                            busy,
   output logic                            res_valid,
   output logic [DATA_W-1:0]               res_data,
   output logic [$clog2(NUM_CH_MAX)-1:0]   res_chan,
   output logic [1:0]                      res_src
);
   localparam int CH_W    = $clog2(NUM_CH_MAX);
   localparam int N_AVG   = 1 << AVG_LOG2;
   localparam int CNT_MAX = (PRIME_CNT > N_AVG) ? PRIME_CNT : N_AVG;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int TAG_W   = CH_W + SRC_W;

   generate
      if (NUM_CH_MAX < 2)
         $error("NUM_CH_MAX must be at least 2");
      if (SETTLE_CYCLES < 1)
         $error("SETTLE_CYCLES must be at least 1");
      if (AVG_LOG2 < 1 || AVG_LOG2 > 12)
         $error("AVG_LOG2 must lie in 1..12");
      if (PRIME_CNT < 0)
         $error("PRIME_CNT must not be negative");
      if (DATA_W < 2)
         $error("DATA_W must be at least 2");
      if (ROUND_MODE != 0 && ROUND_MODE != 1)
         $error("ROUND_MODE must be 0 or 1");
   endgenerate

   logic             settle_load, settle_run, settle_done;
   logic             cnt_clr, cnt_inc;
   logic [CNT_W-1:0] smp_cnt;
   logic             acc_clr, acc_add, acc_last;
   logic [TAG_W-1:0] tag_out;

   cal_seq_ctrl #(
      .NUM_CH_MAX (NUM_CH_MAX),
      .PRIME_CNT  (PRIME_CNT),
      .AVG_LOG2   (AVG_LOG2),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .num_ch      (num_ch),
      .smp_valid   (smp_valid),
      .settle_done (settle_done),
      .smp_cnt     (smp_cnt),
      .settle_load (settle_load),
      .settle_run  (settle_run),
      .cnt_clr     (cnt_clr),
      .cnt_inc     (cnt_inc),
      .acc_clr     (acc_clr),
      .acc_add     (acc_add),
      .acc_last    (acc_last),
      .src_sel     (src_sel),
      .chan_sel    (chan_sel),
      .busy        (busy),
      .res_valid   (res_valid)
   );

   cal_settle_timer #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (settle_load),
      .run     (settle_run),
      .expired (settle_done)
   );

   cal_smp_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (smp_cnt)
   );

   cal_avg_accum #(
      .DATA_W     (DATA_W),
      .AVG_LOG2   (AVG_LOG2),
      .TAG_W      (TAG_W),
      .ROUND_MODE (ROUND_MODE)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr),
      .add     (acc_add),
      .last    (acc_last),
      .din     (smp_data),
      .tag_in  ({chan_sel, src_sel}),
      .avg_out (res_data),
      .tag_out (tag_out)
   );

   assign res_chan = tag_out[TAG_W-1:SRC_W];
   assign res_src  = tag_out[SRC_W-1:0];

endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
   parameter int DATA_W        = 27,
   parameter int NUM_CH_MAX    = 64,
   parameter int SETTLE_CYCLES = 2500,
   parameter int PRIME_CNT     = 4,
   parameter int AVG_LOG2      = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            start,
   input logic [$clog2(NUM_CH_MAX+1)-1:0] num_ch,
   input logic [1:0]                      src_sel,
   input logic [$clog2(NUM_CH_MAX)-1:0]   chan_sel,
   input logic                            busy,
   input logic                            res_valid,
   input logic [$clog2(NUM_CH_MAX)-1:0]   res_chan,
   input logic [1:0]                      res_src
);
   localparam int MIN_GAP = SETTLE_CYCLES + PRIME_CNT + (1 << AVG_LOG2);

   int unsigned gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= 0;
      else if (res_valid || !busy)
         gap_q <= 0;
      else if (gap_q != 32'hFFFF_FFFF)
         gap_q <= gap_q + 1;
   end

   p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && num_ch == '0) |=> !busy);

   p_entry_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (src_sel == 2'd0 && chan_sel == '0));

   p_src_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && src_sel != 2'd3) |=> (src_sel == $past(src_sel) + 2'd1 && $stable(chan_sel)));

   p_settle_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (gap_q >= MIN_GAP));

   p_tag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (busy && res_src == src_sel && res_chan == chan_sel));

   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> ($stable(src_sel) && $stable(chan_sel)));

endmodule

bind adcal_sequencer cal_seq_checker #(
   .DATA_W        (DATA_W),
   .NUM_CH_MAX    (NUM_CH_MAX),
   .SETTLE_CYCLES (SETTLE_CYCLES),
   .PRIME_CNT     (PRIME_CNT),
   .AVG_LOG2      (AVG_LOG2)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .num_ch    (num_ch),
   .src_sel   (src_sel),
   .chan_sel  (chan_sel),
   .busy      (busy),
   .res_valid (res_valid),
   .res_chan  (res_chan),
   .res_src   (res_src)
);

// File: tb/sim_adcal_sequencer.sv
module sim_adcal_sequencer;
   localparam int DW    = 27;
   localparam int NCH   = 64;
   localparam int CW    = 6;
   localparam int NW    = 7;
   localparam int WARM  = 40;
   localparam int PRIME = 4;
   localparam int AL    = 4;
   localparam int NAVG  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NW-1:0] num_ch = '0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic [1:0]    src_sel;
   logic [CW-1:0] chan_sel;
   logic          busy;
   logic          res_valid;
   logic [DW-1:0] res_data;
   logic [CW-1:0] res_chan;
   logic [1:0]    res_src;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   adcal_sequencer #(
      .DATA_W        (DW),
      .NUM_CH_MAX    (NCH),
      .SETTLE_CYCLES (WARM),
      .PRIME_CNT     (PRIME),
      .AVG_LOG2      (AL),
      .ROUND_MODE    (0)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .num_ch    (num_ch),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .src_sel   (src_sel),
      .chan_sel  (chan_sel),
      .busy      (busy),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_chan  (res_chan),
      .res_src   (res_src)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint exp_avg(input longint sum);
      return sum >> AL;
   endfunction

   function automatic int eff_count(input int n);
      return (n > NCH) ? NCH : n;
   endfunction

   function automatic logic [DW-1:0] pick_data(input int mode);
      if (mode == 1) return {DW{1'b1}};
      if (mode == 2) return '0;
      return DW'($urandom);
   endfunction

   // one source: settle (R4), prime (R5), average (R6), ignore gaps (R9), report (R7)
   task automatic run_source(input int ch, input int src, input int mode, input bit poke);
      longint sum = 0;
      logic [DW-1:0] d;
      chk(src_sel == 2'(src), "R3 source order", src_sel, src);
      chk(chan_sel == CW'(ch), "R3 channel order", chan_sel, ch);
      chk(busy == 1'b1, "R2 busy during run", busy, 1);
      chk(res_valid == 1'b0, "R7 strobe low after pulse", res_valid, 0);
      for (int k = 0; k < WARM; k++) begin
         smp_valid = (k == WARM - 1) ? 1'b1 : 1'($urandom % 2);
         smp_data  = DW'($urandom);
         if (poke && k == 5) begin
            start  = 1'b1;
            num_ch = NW'(5);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      for (int i = 0; i < PRIME + NAVG; i++) begin
         if (i > 0 || (ch % 2) == 1) begin
            while (($urandom % 4) == 0) begin
               smp_valid = 1'b0;
               smp_data  = DW'($urandom);
               @(negedge clk);
            end
         end
         d = (i < PRIME) ? DW'($urandom) : pick_data(mode);
         smp_valid = 1'b1;
         smp_data  = d;
         if (i >= PRIME) sum += longint'(d);
         @(negedge clk);
      end
      smp_valid = 1'b0;
      smp_data  = DW'($urandom);
      chk(res_valid == 1'b1, "R7 result strobe", res_valid, 1);
      chk(longint'(res_data) == exp_avg(sum), "R6 average value", res_data, exp_avg(sum));
      chk(res_chan == CW'(ch) && res_src == 2'(src), "R7 result tag",
          {res_chan, res_src}, (ch << 2) | src);
      @(negedge clk);
   endtask

   task automatic run_seq(input int cnt, input int mode, input bit poke_once);
      int n = eff_count(cnt);
      num_ch = NW'(cnt);
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int ch = 0; ch < n; ch++)
         for (int s = 0; s < 4; s++)
            run_source(ch, s, mode, poke_once && ch == 0 && s == 1);
      chk(busy == 1'b0, "R8 busy falls after last result", busy, 0);
      chk(src_sel == 2'd0 && chan_sel == '0, "R8 selects return to zero", {chan_sel, src_sel}, 0);
      chk(res_valid == 1'b0, "R7 no extra strobe", res_valid, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && res_valid == 1'b0, "R1 reset outputs", {busy, res_valid}, 0);
      chk(src_sel == 2'd0 && chan_sel == '0, "R1 reset selects", {chan_sel, src_sel}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 idle after reset", busy, 0);

      // R2: zero count does not start
      num_ch = '0;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b0, "R2 zero count ignored", busy, 0);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R2 zero count stays idle", busy, 0);

      // R2 restart ignored while busy, R9 gaps, random data
      run_seq(2, 0, 1'b1);
      // R6 full-scale and all-zero inputs
      run_seq(1, 1, 1'b0);
      run_seq(1, 2, 1'b0);
      // R10 count above maximum clamps to 64 channels
      run_seq(100, 0, 1'b0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R10 no channels past the maximum", busy, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule